// File: doc/BRIEF.md
# Half-Warp Load Coalescer

The block takes one group of sixteen per-lane load requests. Each lane has an address and an active flag, and all lanes share one element size of 4, 8 or 16 bytes. The block decides whether the group can be served with wide aligned memory transactions, or whether each active lane must get a load of its own. It then sends the resulting transactions on a valid/ready memory port, one per cycle. The lane mask sent with each transaction tells downstream logic which lanes that transaction serves.

A group qualifies for the wide path only when all of the following hold:
- every active lane k sits at `base + k × element size`;
- `base` is a multiple of sixteen times the element size;
- at least one lane is active.

A qualifying group of 4-byte or 8-byte elements becomes a single transaction. A qualifying group of 16-byte elements becomes two transactions of 128 bytes each, one for each half of the lanes. Any other group is served lane by lane, in ascending lane order. When the group is finished, the block pulses `done` and holds the number of transactions it used on `txn_count`.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_valid` is 0, `done` is 0 and `txn_count` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` falls on the edge after acceptance and rises again in the cycle that `done` is high. A `req_valid` raised while busy has no effect on any transaction.
- R3: Size code 0 means 4-byte elements. A qualifying group produces exactly one transaction: `mem_addr` is the base, `mem_bytes` is 64 and `mem_lane_mask` equals the active mask.
- R4: Size code 1 means 8-byte elements. A qualifying group produces exactly one transaction of 128 bytes at the base, with the active mask as its lane mask.
- R5: Size code 2 means 16-byte elements. A qualifying group produces two 128-byte transactions, the first at the base and the second at base+128. Their lane masks are the active mask restricted to lanes 0–7 and to lanes 8–15. Both are issued even if one half has no active lane.
- R6: Contiguity is judged only over active lanes. The base is the address of the lowest active lane minus its lane number times the element size. Addresses on inactive lanes have no effect.
- R7: A group whose derived base is not a multiple of 16 × element size (64, 128 or 256 bytes) is served lane by lane, even when it is contiguous.
- R8: A group that fails the contiguity or alignment test gets one transaction per active lane, in ascending lane order. Each carries the lane's own address, `mem_bytes` equal to the element size, and a one-hot lane mask.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, the outputs `mem_addr`, `mem_bytes` and `mem_lane_mask` hold their values.
- R10: `done` is high for exactly the one cycle after the edge that accepts the last transaction. `txn_count` then equals the number of transactions issued and holds until the next request is accepted. A group with no active lane issues nothing and raises `done` one cycle after `mem_valid` would first have risen, with a count of 0.
- R11: Size code 3 behaves exactly like size code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A new lane group is offered |
| req_ready | output | 1 | Block idle, the group will be taken |
| req_size | input | 2 | Element size code: 0=4, 1=8, 2 or 3=16 bytes |
| req_active | input | LANES | Active flag per lane |
| req_addr | input | LANES×ADDR_W | Byte address per lane, lane k at bits k×ADDR_W upward |
| mem_valid | output | 1 | A transaction is presented |
| mem_ready | input | 1 | Memory takes the presented transaction |
| mem_addr | output | ADDR_W | Start byte address of the transaction |
| mem_bytes | output | $clog2(LANES×8)+1 | Transaction length in bytes |
| mem_lane_mask | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse, group complete |
| txn_count | output | $clog2(LANES+1) | Transactions used by the last group |

## Verification
The bench targets the following corner cases:
- A group that is contiguous but misaligned by one element. A design that checked only spacing would send a single wide load there.
- A lowest active lane other than lane 0. This catches a base taken from lane 0's address, which would reject or misplace the group.
- Garbage addresses on inactive lanes, which must not break the wide path or add lane loads.
- A 16-byte group with an empty upper half, and size code 3. Here a wrong design drops the second transaction or uses the wrong length.
- An empty group, which must finish with a count of zero.

Memory stalls from an irregular ready pattern, and request pulses while busy, expose transactions that move under a stall or a second group that is captured too early.

// File: rtl/hwc_pkg.sv
// Shared definitions for the half-warp load coalescer.
// Assumes element size codes 0..3 as listed in the brief.
package hwc_pkg;

    // Log2 of the element size in bytes for a request size code.
    function automatic logic [2:0] elem_lg(input logic [1:0] code);
        case (code)
            2'd0:    elem_lg = 3'd2;
            2'd1:    elem_lg = 3'd3;
            default: elem_lg = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/hwc_lane_pick.sv
// Finds the lowest set bit of a mask.
// Outputs its index, a one-hot copy and a found flag.
// Purely combinational; assumes N is a power of two.
module hwc_lane_pick #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        onehot = found ? (N'(1) << idx) : '0;
    end

endmodule

// File: rtl/hwc_analyzer.sv
// Decides whether a lane group qualifies for wide transactions.
// The base is derived from the lowest active lane.
// Every active lane must sit at base + lane * element size.
// The base must be aligned to LANES * element size.
// Assumes the inputs are stable for the cycle in which they are sampled.
module hwc_analyzer #(
    parameter  int LANES   = 16,
    parameter  int ADDR_W  = 32,
    localparam int LANE_LG = $clog2(LANES)
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        active,
    input  logic [2:0]              lg,
    output logic                    coalesced,
    output logic [ADDR_W-1:0]       base
);

    logic               any_act;
    logic [LANE_LG-1:0] first_idx;
    logic [LANES-1:0]   first_oh;
    logic [ADDR_W-1:0]  first_addr;
    logic [LANES-1:0]   lane_ok;
    logic [ADDR_W-1:0]  align_mask;

    hwc_lane_pick #(.N(LANES)) u_first (
        .mask   (active),
        .found  (any_act),
        .idx    (first_idx),
        .onehot (first_oh)
    );

    // Select the lowest active lane's address with an and-or mux.
    always_comb begin
        first_addr = '0;
        for (int k = 0; k < LANES; k++) begin
            first_addr = first_addr | (addr_flat[k*ADDR_W +: ADDR_W] & {ADDR_W{first_oh[k]}});
        end
    end

    // Project the lowest active lane back to lane 0.
    assign base = first_addr - (ADDR_W'(first_idx) << lg);

    // Per-lane contiguity test; inactive lanes always pass.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ok[k] = !active[k] ||
            (addr_flat[k*ADDR_W +: ADDR_W] == base + (ADDR_W'(k) << lg));
    end

    // Region alignment mask for LANES elements.
    assign align_mask = (ADDR_W'(1) << (ADDR_W'(lg) + ADDR_W'(LANE_LG))) - ADDR_W'(1);

    // Final verdict: something active, all contiguous, region aligned.
    assign coalesced = any_act && (&lane_ok) && ((base & align_mask) == '0);

endmodule

// File: rtl/hwc_issuer.sv
// Captures an accepted group and issues its transactions on the memory port.
// A pending mask holds transaction slots: lanes for the lane-by-lane path,
// or one or two chunk slots for the wide path.
// Also pulses done and keeps the transaction count.
// Assumes the analyzer verdict belongs to the request on the same cycle.
module hwc_issuer #(
    parameter  int LANES   = 16,
    parameter  int ADDR_W  = 32,
    localparam int LANE_LG = $clog2(LANES),
    localparam int BYTES_W = $clog2(LANES * 8) + 1,
    localparam int CNT_W   = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        active,
    input  logic [2:0]              lg_in,
    input  logic                    coal_in,
    input  logic [ADDR_W-1:0]       base_in,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTES_W-1:0]      mem_bytes,
    output logic [LANES-1:0]        mem_lane_mask,
    output logic                    done,
    output logic [CNT_W-1:0]        txn_count
);

    localparam logic [LANES-1:0] LOW_HALF = (LANES'(1) << (LANES / 2)) - LANES'(1);

    logic                    busy_q;
    logic                    done_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        act_q;
    logic [2:0]              lg_q;
    logic                    coal_q;
    logic [ADDR_W-1:0]       base_q;

    logic                    has_pend;
    logic [LANE_LG-1:0]      nidx;
    logic [LANES-1:0]        noh;
    logic [ADDR_W-1:0]       lane_addr;
    logic [LANES-1:0]        pend_init;
    logic [LANES-1:0]        pend_next;

    hwc_lane_pick #(.N(LANES)) u_next (
        .mask   (pend_q),
        .found  (has_pend),
        .idx    (nidx),
        .onehot (noh)
    );

    // Address of the lane currently selected on the lane-by-lane path.
    always_comb begin
        lane_addr = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_addr = lane_addr | (addr_q[k*ADDR_W +: ADDR_W] & {ADDR_W{noh[k]}});
        end
    end

    // Initial pending slots: one or two chunks when wide, else the active lanes.
    always_comb begin
        if (coal_in) begin
            pend_init = (lg_in == 3'd4) ? LANES'(3) : LANES'(1);
        end else begin
            pend_init = active;
        end
    end

    assign pend_next = pend_q & ~noh;

    // Present the transaction for the lowest pending slot.
    always_comb begin
        if (coal_q) begin
            mem_addr = base_q + (ADDR_W'(nidx) << (LANE_LG + 3));
            if (lg_q == 3'd4) begin
                mem_bytes     = BYTES_W'(LANES * 8);
                mem_lane_mask = act_q & ((nidx == '0) ? LOW_HALF : ~LOW_HALF);
            end else begin
                mem_bytes     = BYTES_W'(LANES) << lg_q;
                mem_lane_mask = act_q;
            end
        end else begin
            mem_addr      = lane_addr;
            mem_bytes     = BYTES_W'(1) << lg_q;
            mem_lane_mask = noh;
        end
    end

    assign req_ready = !busy_q;
    assign mem_valid = busy_q && has_pend;
    assign done      = done_q;
    assign txn_count = cnt_q;

    // Group capture, slot retirement, completion pulse and counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
            addr_q <= '0;
            act_q  <= '0;
            lg_q   <= 3'd2;
            coal_q <= 1'b0;
            base_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (req_valid) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    pend_q <= pend_init;
                    addr_q <= addr_flat;
                    act_q  <= active;
                    lg_q   <= lg_in;
                    coal_q <= coal_in;
                    base_q <= base_in;
                end
            end else if (!has_pend) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else if (mem_ready) begin
                pend_q <= pend_next;
                cnt_q  <= cnt_q + CNT_W'(1);
                if (pend_next == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // A stalled transaction must not change.
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
            && $stable(mem_bytes) && $stable(mem_lane_mask));

    // No second group is taken straight after one is accepted.
    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // Completion leaves the block idle with nothing presented.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready && !mem_valid);

    // A group never uses more transactions than lanes.
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_count <= CNT_W'(LANES));

    // Wide transactions start on a boundary of their own length.
    p_wide_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && coal_q |-> (mem_addr & (ADDR_W'(mem_bytes) - ADDR_W'(1))) == '0);

endmodule

// File: rtl/hwc_coalescer.sv
// Top of the half-warp load coalescer.
// The analyzer judges the offered group combinationally.
// The issuer captures the group with that verdict and sends the transactions.
// Assumes requests are held until req_ready is seen.
module hwc_coalescer #(
    parameter  int LANES   = 16,
    parameter  int ADDR_W  = 32,
    localparam int BYTES_W = $clog2(LANES * 8) + 1,
    localparam int CNT_W   = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_size,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTES_W-1:0]      mem_bytes,
    output logic [LANES-1:0]        mem_lane_mask,
    output logic                    done,
    output logic [CNT_W-1:0]        txn_count
);

    import hwc_pkg::*;

    logic [2:0]        lg;
    logic              coal;
    logic [ADDR_W-1:0] base;

    // Decode the element size code.
    assign lg = elem_lg(req_size);

    hwc_analyzer #(.LANES(LANES), .ADDR_W(ADDR_W)) u_analyzer (
        .addr_flat (req_addr),
        .active    (req_active),
        .lg        (lg),
        .coalesced (coal),
        .base      (base)
    );

    hwc_issuer #(.LANES(LANES), .ADDR_W(ADDR_W)) u_issuer (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .addr_flat     (req_addr),
        .active        (req_active),
        .lg_in         (lg),
        .coal_in       (coal),
        .base_in       (base),
        .mem_valid     (mem_valid),
        .mem_ready     (mem_ready),
        .mem_addr      (mem_addr),
        .mem_bytes     (mem_bytes),
        .mem_lane_mask (mem_lane_mask),
        .done          (done),
        .txn_count     (txn_count)
    );

endmodule

// File: tb/hwc_coalescer_bench.sv
module hwc_coalescer_bench;

    localparam int LANES  = 16;
    localparam int ADDR_W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_size = 2'd0;
    logic [15:0]  req_active = '0;
    logic [511:0] req_addr = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [31:0]  mem_addr;
    logic [7:0]   mem_bytes;
    logic [15:0]  mem_lane_mask;
    logic         done;
    logic [4:0]   txn_count;

    hwc_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) u_hwc_coalescer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_active(req_active), .req_addr(req_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_lane_mask(mem_lane_mask), .done(done),
        .txn_count(txn_count)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;

    logic [31:0] lane_a [16];
    logic [31:0] qa [$];
    int          qb [$];
    logic [15:0] qm [$];
    int          exp_cnt = 0;
    bit          run = 0;
    bit          bench_busy = 0;
    bit          grp_finished = 1;
    bit          zero_flag = 0;
    bit          exp_done_next = 0;
    bit          exp_done_now = 0;
    bit          rdy_mode = 0;
    logic [7:0]  lfsr = 8'hA5;
    string       cur_req = "R3";
    int          cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected transactions, derived from the requirements.
    task automatic build_expect(input logic [15:0] act, input logic [1:0] sz);
        int es;
        int first;
        bit ok;
        logic [31:0] base;
        es = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 8 : 16;
        first = -1;
        for (int k = 0; k < 16; k++) if (act[k] && first < 0) first = k;
        ok = (first >= 0);
        base = '0;
        if (ok) begin
            base = lane_a[first] - 32'(first * es);
            for (int k = 0; k < 16; k++)
                if (act[k] && lane_a[k] != base + 32'(k * es)) ok = 0;
            if ((base % 32'(16 * es)) != 0) ok = 0;
        end
        if (ok) begin
            if (es == 16) begin
                qa.push_back(base);         qb.push_back(128); qm.push_back(act & 16'h00FF);
                qa.push_back(base + 128);   qb.push_back(128); qm.push_back(act & 16'hFF00);
            end else begin
                qa.push_back(base); qb.push_back(16 * es); qm.push_back(act);
            end
        end else begin
            for (int k = 0; k < 16; k++)
                if (act[k]) begin
                    qa.push_back(lane_a[k]); qb.push_back(es); qm.push_back(16'(1) << k);
                end
        end
        exp_cnt = qa.size();
    endtask

    // Per-cycle comparison against the queue model; also drives mem_ready.
    always @(negedge clk) begin
        if (run) begin
            cycles++;
            exp_done_now  = exp_done_next;
            exp_done_next = 0;
            if (exp_done_now) begin
                bench_busy   = 0;
                grp_finished = 1;
            end
            chk(done == exp_done_now, "R10", "done", 32'(done), 32'(exp_done_now));
            if (exp_done_now)
                chk(txn_count == 5'(exp_cnt), "R10", "txn_count", 32'(txn_count), 32'(exp_cnt));
            chk(req_ready == !bench_busy, "R2", "req_ready", 32'(req_ready), 32'(!bench_busy));
            chk(mem_valid == (qa.size() > 0), cur_req, "mem_valid",
                32'(mem_valid), 32'(qa.size() > 0));
            if (mem_valid && qa.size() > 0) begin
                chk(mem_addr == qa[0], cur_req, "mem_addr (R9 hold)", mem_addr, qa[0]);
                chk(32'(mem_bytes) == 32'(qb[0]), cur_req, "mem_bytes", 32'(mem_bytes), 32'(qb[0]));
                chk(mem_lane_mask == qm[0], cur_req, "lane_mask", 32'(mem_lane_mask), 32'(qm[0]));
            end
            if (zero_flag) begin
                zero_flag     = 0;
                exp_done_next = 1;
            end
            mem_ready = rdy_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (mem_valid && mem_ready && qa.size() > 0) begin
                void'(qa.pop_front()); void'(qb.pop_front()); void'(qm.pop_front());
                if (qa.size() == 0) exp_done_next = 1;
            end
            if (cycles > 20000) begin
                bad++;
                total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    // Offer one group, poke while busy, wait for completion.
    task automatic send(input logic [1:0] sz, input logic [15:0] act, input string req);
        @(negedge clk); #1;
        for (int k = 0; k < 16; k++) req_addr[k*32 +: 32] = lane_a[k];
        req_active   = act;
        req_size     = sz;
        req_valid    = 1'b1;
        cur_req      = req;
        build_expect(act, sz);
        bench_busy   = 1;
        grp_finished = 0;
        if (exp_cnt == 0) zero_flag = 1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (exp_cnt > 0) begin
            // R2: a request while busy must be ignored.
            req_active = 16'hFFFF;
            req_size   = 2'd1;
            req_valid  = 1'b1;
            @(negedge clk); #1;
            req_valid  = 1'b0;
        end
        do begin @(negedge clk); #2; end while (!grp_finished);
    endtask

    task automatic fill(input logic [31:0] base, input int es);
        for (int k = 0; k < 16; k++) lane_a[k] = base + 32'(k * es);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
        chk(mem_valid == 1'b0, "R1", "mem_valid", 32'(mem_valid), 0);
        chk(done == 1'b0, "R1", "done", 32'(done), 0);
        chk(txn_count == 5'd0, "R1", "txn_count", 32'(txn_count), 0);
        run = 1;

        fill(32'h1000, 4);  send(2'd0, 16'hFFFF, "R3");
        fill(32'h2000, 8);  send(2'd1, 16'hFFFF, "R4");
        fill(32'h3000, 16); send(2'd2, 16'hFFFF, "R5");
        rdy_mode = 1;
        fill(32'h1004, 4);  send(2'd0, 16'hFFFF, "R7");
        fill(32'h1000, 4); lane_a[5] = 32'h1018; lane_a[6] = 32'h1014;
        send(2'd0, 16'hFFFF, "R8");
        fill(32'h4000, 4); lane_a[2] = 32'hDEAD0000; lane_a[9] = 32'h12345678;
        send(2'd0, 16'hFDFB, "R6");
        fill(32'h5000, 8); lane_a[0] = 32'h0; lane_a[1] = 32'h77; lane_a[2] = 32'h9;
        send(2'd1, 16'hFFF8, "R6");
        fill(32'h6010, 4);  send(2'd0, 16'h8421 | 16'h0100, "R8");
        send(2'd1, 16'h0000, "R10");
        fill(32'h7000, 16); send(2'd3, 16'hFFFF, "R11");
        fill(32'h7100, 16); send(2'd2, 16'h00F0, "R5");
        fill(32'h8040, 8);  send(2'd1, 16'hFFFF, "R7");
        rdy_mode = 0;
        fill(32'h9000, 4);  send(2'd0, 16'h0001, "R3");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule